// File: doc/BRIEF.md
# Ethernet Receive Clock Speed Classifier

This block decides, in hardware alone, which of the three tri-speed Ethernet line rates a PHY has negotiated. It does this by measuring the frequency of the PHY's receive clock against a system clock that is at least as fast. A small divider running on the receive clock emits a tick every fourth receive cycle. Each tick flips a toggle flag, and the system domain resynchronises that flag and turns every change into a single-cycle pulse. A pulse counter in the system domain accumulates these pulses over a fixed window whose length is derived from the system clock frequency.

When the window closes, the frozen count is compared against three inclusive pulse-count bands. The bands are computed at elaboration from a 2.5 MHz, 25 MHz and 125 MHz target with a ±1 MHz tolerance, so no multiplier is needed. The result is a speed code, a MII/GMII mode bit, a fail flag and a one-cycle done strobe. A measurement starts on a start request. The results stay in place until the next measurement finishes. The raw count is also visible at the ports.

Top module: `eth_rx_speed_detect`

## Requirements
- R1: After reset, mode_o is 0, speed_o is 2'b11, fail_o is 0, done_o is 0 and count_o is 0.
- R2: During a window, count_o advances by at most one per system cycle. At the end of the window it equals (receive frequency × window seconds / 4) within ±2.
- R3: A start request accepted while idle produces done_o exactly WIN_CYC+2 system cycles later, where WIN_CYC = SYS_CLK_HZ / WIN_RATE. done_o is high for exactly one cycle.
- R4: A count inside the 10 Mb/s band gives speed_o = 2'b00, mode_o = 1 (MII) and fail_o = 0.
- R5: A count inside the 100 Mb/s band gives speed_o = 2'b01, mode_o = 1 (MII) and fail_o = 0.
- R6: A count inside the 1 Gb/s band gives speed_o = 2'b10, mode_o = 0 (GMII) and fail_o = 0.
- R7: A count outside all bands, including a stopped receive clock, gives speed_o = 2'b11 and fail_o = 1, and leaves mode_o at its previous value.
- R8: speed_o, mode_o and fail_o change only when a measurement completes. A start request that arrives during a measurement is ignored and produces no extra done_o.
- R9: count_o is cleared at the start of each measurement and stays frozen between measurements.
- R10: Each band is inclusive. Its lower bound is floor((target − margin) / (4 × WIN_RATE)) and its upper bound is floor((target + margin) / (4 × WIN_RATE)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, at least as fast as rx_clk |
| rx_clk | input | 1 | PHY receive clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| start_i | input | 1 | Measurement request, synchronous to sys_clk |
| mode_o | output | 1 | 1 = MII (10/100), 0 = GMII (1000) |
| speed_o | output | 2 | 00 = 10M, 01 = 100M, 10 = 1G, 11 = unknown |
| done_o | output | 1 | One-cycle strobe when a result is ready |
| fail_o | output | 1 | No band matched in the last measurement |
| count_o | output | CNT_W | Pulse count of the current or last window |

## Verification
The in-RTL assertions rely on two assumptions about the inputs. First, start_i is synchronous to sys_clk. Second, rx_clk never runs faster than sys_clk, so synchronised pulses are never back to back and the counter rises by at most one per cycle. The bench drives receive periods no shorter than the 8 ns system period, with a phase offset between the clocks. It also uses a fully stopped receive clock. start_i is driven only on falling system edges. The window rate is raised so that a window lasts 5000 system cycles and the bands become 15–35, 240–260 and 1240–1260 counts.

// File: rtl/eth_spd_pkg.sv
package eth_spd_pkg;

  typedef enum logic [1:0] {
    SPD_10M  = 2'b00,
    SPD_100M = 2'b01,
    SPD_1G   = 2'b10,
    SPD_NONE = 2'b11
  } spd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLR,
    ST_MEAS,
    ST_EVAL
  } meas_st_e;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic toggle_o
);

  logic [DIV_W-1:0] div_q, div_d;
  logic             tgl_q, tgl_d;
  logic             tick;

  always_comb begin
    tick  = (div_q == '0);
    div_d = div_q + 1'b1;
    tgl_d = tick ? ~tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      div_q <= div_d;
      tgl_q <= tgl_d;
    end
  end

  assign toggle_o = tgl_q;

  // R2
  tick_sparse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(toggle_o));

endmodule

// File: rtl/pulse_xfer.sv
module pulse_xfer #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_i,
  output logic pulse_o
);

  logic [SYNC_STAGES:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], toggle_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign pulse_o = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  // R2
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/speed_meter.sv
module speed_meter
  import eth_spd_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 125_000_000,
  parameter int unsigned WIN_RATE   = 10,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned MARGIN_HZ  = 1_000_000,
  parameter int unsigned T10_HZ     = 2_500_000,
  parameter int unsigned T100_HZ    = 25_000_000,
  parameter int unsigned T1G_HZ     = 125_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pulse_i,
  output logic             mode_o,
  output logic [1:0]       speed_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int unsigned WIN_CYC    = SYS_CLK_HZ / WIN_RATE;
  localparam int unsigned WIN_W      = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int unsigned HZ_PER_CNT = TICK_DIV * WIN_RATE;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  localparam logic [CNT_W-1:0] LO_10  = CNT_W'((T10_HZ  - MARGIN_HZ) / HZ_PER_CNT);
  localparam logic [CNT_W-1:0] HI_10  = CNT_W'((T10_HZ  + MARGIN_HZ) / HZ_PER_CNT);
  localparam logic [CNT_W-1:0] LO_100 = CNT_W'((T100_HZ - MARGIN_HZ) / HZ_PER_CNT);
  localparam logic [CNT_W-1:0] HI_100 = CNT_W'((T100_HZ + MARGIN_HZ) / HZ_PER_CNT);
  localparam logic [CNT_W-1:0] LO_1G  = CNT_W'((T1G_HZ  - MARGIN_HZ) / HZ_PER_CNT);
  localparam logic [CNT_W-1:0] HI_1G  = CNT_W'((T1G_HZ  + MARGIN_HZ) / HZ_PER_CNT);

  meas_st_e         st_q, st_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;
  spd_e             spd_q, spd_d;
  logic             fail_q, fail_d;
  logic             done_q, done_d;
  logic             in10, in100, in1g;
  logic             res_en;

  always_comb begin
    in10   = (cnt_q >= LO_10)  && (cnt_q <= HI_10);
    in100  = (cnt_q >= LO_100) && (cnt_q <= HI_100);
    in1g   = (cnt_q >= LO_1G)  && (cnt_q <= HI_1G);
    res_en = (st_q == ST_EVAL);

    st_d   = st_q;
    win_d  = win_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    mode_d = mode_q;
    spd_d  = spd_q;
    fail_d = fail_q;

    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_CLR;
      ST_CLR: begin
        cnt_d = '0;
        win_d = '0;
        st_d  = ST_MEAS;
      end
      ST_MEAS: begin
        if (pulse_i) cnt_d = cnt_q + 1'b1;
        if (win_q == WIN_LAST) st_d = ST_EVAL;
        else                   win_d = win_q + 1'b1;
      end
      ST_EVAL: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    if (res_en) begin
      fail_d = 1'b0;
      if (in10) begin
        spd_d  = SPD_10M;
        mode_d = 1'b1;
      end else if (in100) begin
        spd_d  = SPD_100M;
        mode_d = 1'b1;
      end else if (in1g) begin
        spd_d  = SPD_1G;
        mode_d = 1'b0;
      end else begin
        spd_d  = SPD_NONE;
        fail_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      win_q  <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      spd_q  <= SPD_NONE;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (res_en) begin
        mode_q <= mode_d;
        spd_q  <= spd_d;
        fail_q <= fail_d;
      end
    end
  end

  assign mode_o  = mode_q;
  assign speed_o = spd_q;
  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign count_o = cnt_q;

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fail_o == (speed_o == SPD_NONE)));

  // R4 R5 R6
  mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fail_o) |-> (mode_o == (speed_o != SPD_1G)));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> $stable(count_o));

  // R9
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CLR) |=> (count_o == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MEAS) |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_EVAL) |=> ($stable(speed_o) && $stable(mode_o) && $stable(fail_o)));

endmodule

// File: rtl/eth_rx_speed_detect.sv
module eth_rx_speed_detect #(
  parameter int unsigned SYS_CLK_HZ = 125_000_000,
  parameter int unsigned WIN_RATE   = 10,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MARGIN_HZ  = 1_000_000
) (
  input  logic             sys_clk,
  input  logic             rx_clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             mode_o,
  output logic [1:0]       speed_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int unsigned DIV_W    = 2;
  localparam int unsigned TICK_DIV = 1 << DIV_W;

  logic sys_rst_n, rx_rst_n;
  logic rx_toggle, sys_pulse;

  rst_sync #(.STAGES(2)) u_sys_rst (
    .clk(sys_clk), .arst_n(rst_n), .rst_n_o(sys_rst_n)
  );

  rst_sync #(.STAGES(2)) u_rx_rst (
    .clk(rx_clk), .arst_n(rst_n), .rst_n_o(rx_rst_n)
  );

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(rx_clk), .rst_n(rx_rst_n), .toggle_o(rx_toggle)
  );

  pulse_xfer #(.SYNC_STAGES(2)) u_xfer (
    .clk(sys_clk), .rst_n(sys_rst_n), .toggle_i(rx_toggle), .pulse_o(sys_pulse)
  );

  speed_meter #(
    .SYS_CLK_HZ(SYS_CLK_HZ),
    .WIN_RATE  (WIN_RATE),
    .CNT_W     (CNT_W),
    .TICK_DIV  (TICK_DIV),
    .MARGIN_HZ (MARGIN_HZ)
  ) u_meter (
    .clk    (sys_clk),
    .rst_n  (sys_rst_n),
    .start_i(start_i),
    .pulse_i(sys_pulse),
    .mode_o (mode_o),
    .speed_o(speed_o),
    .done_o (done_o),
    .fail_o (fail_o),
    .count_o(count_o)
  );

endmodule

// File: tb/eth_rx_speed_detect_bench.sv
module eth_rx_speed_detect_bench;

  localparam int CNT_W   = 32;
  localparam int WIN_CYC = 5000;   // 125 MHz / 25000
  localparam int NVEC    = 10;

  // receive period (ps), expected speed code (3 = fail); count = 10_000_000 / period
  localparam int P_PS [NVEC] = '{8000, 37036, 40000, 20000, 400000,
                                 39216, 8130, 303030, 250000, 100000};
  localparam int E_SPD[NVEC] = '{2, 3, 1, 3, 0, 1, 3, 0, 3, 3};

  logic             sys_clk, rx_clk, rst_n, start;
  logic             mode;
  logic [1:0]       speed;
  logic             done, fail;
  logic [CNT_W-1:0] count;

  int  n_chk, n_bad;
  int  rx_half;
  bit  rx_run;
  bit  cur_mode;

  eth_rx_speed_detect #(
    .SYS_CLK_HZ(125_000_000), .WIN_RATE(25_000), .CNT_W(CNT_W), .MARGIN_HZ(1_000_000)
  ) u_eth_rx_speed_detect (
    .sys_clk(sys_clk), .rx_clk(rx_clk), .rst_n(rst_n), .start_i(start),
    .mode_o(mode), .speed_o(speed), .done_o(done), .fail_o(fail), .count_o(count)
  );

  initial begin
    sys_clk = 1'b0;
    forever #4000 sys_clk = ~sys_clk;
  end

  initial begin
    rx_clk = 1'b0;
    #3000;
    forever begin
      if (rx_run) #(rx_half) rx_clk = ~rx_clk;
      else        #1000;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // issue a start, measure latency to done, check done width
  task automatic run_meas(input bit poke_busy, output int lat);
    int extra_done;
    @(negedge sys_clk) start = 1'b1;
    @(negedge sys_clk) start = 1'b0;
    lat = 0;
    extra_done = 0;
    while (!done && lat < WIN_CYC + 50) begin
      @(negedge sys_clk);
      lat++;
      if (poke_busy && lat == 100) start = 1'b1;
      if (poke_busy && lat == 101) start = 1'b0;
    end
    check(lat == WIN_CYC + 2, "R3", "done latency", lat, WIN_CYC + 2);
    @(negedge sys_clk);
    check(done == 1'b0, "R3", "done width", int'(done), 0);
    if (poke_busy) begin
      for (int i = 0; i < 200; i++) begin
        @(negedge sys_clk);
        if (done) extra_done++;
      end
      check(extra_done == 0, "R8", "extra done after busy start", extra_done, 0);
    end
  endtask

  initial begin
    int lat, exp_cnt, exp_mode, diff;
    n_chk = 0; n_bad = 0;
    start = 1'b0; rst_n = 1'b0;
    rx_run = 1'b1; rx_half = 4000;
    cur_mode = 1'b0;
    repeat (5) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge sys_clk);

    // R1 reset state
    check(mode == 1'b0,   "R1", "mode",  int'(mode),  0);
    check(speed == 2'b11, "R1", "speed", int'(speed), 3);
    check(fail == 1'b0,   "R1", "fail",  int'(fail),  0);
    check(done == 1'b0,   "R1", "done",  int'(done),  0);
    check(count == '0,    "R1", "count", int'(count), 0);

    // table walk: R2 R4 R5 R6 R7, band edges R10 (255 in, 270 out, 1230 out, 33 in, 40 out)
    for (int v = 0; v < NVEC; v++) begin
      rx_half = P_PS[v] / 2;
      repeat (20) @(negedge sys_clk);
      run_meas(v == 2, lat);
      exp_cnt = 10_000_000 / P_PS[v];
      diff = int'(count) - exp_cnt;
      check(diff <= 2 && diff >= -2, "R2", "count", int'(count), exp_cnt);
      if (E_SPD[v] == 3) exp_mode = int'(cur_mode);
      else               exp_mode = (E_SPD[v] == 2) ? 0 : 1;
      check(int'(speed) == E_SPD[v], (E_SPD[v] == 3) ? "R7" : "R10", "speed",
            int'(speed), E_SPD[v]);
      check(int'(mode) == exp_mode, (E_SPD[v] == 3) ? "R7" : "R4/R5/R6", "mode",
            int'(mode), exp_mode);
      check(int'(fail) == ((E_SPD[v] == 3) ? 1 : 0), "R7", "fail", int'(fail),
            (E_SPD[v] == 3) ? 1 : 0);
      cur_mode = mode;
    end

    // R9 / R8: frozen between runs, results held
    begin
      logic [CNT_W-1:0] c0;
      logic [1:0]       s0;
      c0 = count; s0 = speed;
      repeat (300) @(negedge sys_clk);
      check(count == c0, "R9", "count frozen", int'(count), int'(c0));
      check(speed == s0, "R8", "speed held",   int'(speed), int'(s0));
    end

    // R6 then R7 with stopped clock: count cleared to 0, mode held at GMII
    rx_half = 4000;
    repeat (20) @(negedge sys_clk);
    run_meas(1'b0, lat);
    check(speed == 2'b10, "R6", "speed 1G", int'(speed), 2);
    check(mode == 1'b0,   "R6", "mode GMII", int'(mode), 0);
    rx_run = 1'b0;
    repeat (50) @(negedge sys_clk);
    run_meas(1'b0, lat);
    check(count == '0,    "R9", "count after stopped clock", int'(count), 0);
    check(fail == 1'b1,   "R7", "fail stopped", int'(fail), 1);
    check(speed == 2'b11, "R7", "speed stopped", int'(speed), 3);
    check(mode == 1'b0,   "R7", "mode held", int'(mode), 0);

    // R4 after restart
    rx_run = 1'b1; rx_half = 200000;
    repeat (20) @(negedge sys_clk);
    run_meas(1'b0, lat);
    check(speed == 2'b00, "R4", "speed 10M", int'(speed), 0);
    check(mode == 1'b1,   "R4", "mode MII",  int'(mode), 1);
    check(fail == 1'b0,   "R4", "fail clear", int'(fail), 0);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule